// File: doc/BRIEF.md
# I2C Target Address Front End with Four-State Strap

This block is the receiving front end of an I2C target that runs on a system clock well above the bus rate. It passes SCL, SDA and one address-strap pin through two-flop synchronisers. It finds START and STOP conditions on the synchronised lines and shifts in the address byte MSB first. When the 7-bit address matches its own, it pulls SDA low for the acknowledge clock. For a write it then takes in data bytes, presents each one with a one-cycle strobe, and acknowledges each one.

The target address is built from fixed bits plus two bits that depend on how the strap pin is wired. The pin can be tied to ground, to supply, to SCL or to SDA, so up to four targets can share one bus. The block works out which of the four ties applies at every START by comparing the strap with the bus lines. At a START, a pin that drops together with SDA is tied to SDA. A pin that is high at the START and drops at the next SCL fall is tied to SCL. A pin that stays high is tied to supply, and one that stays low is tied to ground.

When the address does not match, the block leaves SDA released and ignores the bus until the next START. Sending read data is handled elsewhere. After a read address is acknowledged, the block only holds the direction flag.

Top module: `i2c_strap_target`

## Requirements
- R1: While reset is high and after it falls, `sda_oe`, `addr_match`, `rd_wr` and `wr_valid` are all 0.
- R2: The address byte is {A7,1,0,0,A3,0,0,RW}, MSB first. With the strap tied to ground, A7=0 and A3=0, so write byte 0x40 is acknowledged: SDA is held low throughout SCL high in the ninth clock. With supply, A7=0 and A3=1, giving 0x48. Any other address is not acknowledged.
- R3: With the strap tied to SDA, A7=1 and A3=1: byte 0xC8 is acknowledged and 0xC0 is not.
- R4: With the strap tied to SCL, A7=1 and A3=0: byte 0xC0 is acknowledged and 0xC8 is not.
- R5: After an address that does not match, `addr_match` stays 0. SDA stays released, and no `wr_valid` pulse appears for any byte until the next START.
- R6: After a matched address, `rd_wr` equals bit 0 of the address byte (1 means read). After a read address, later bytes are neither acknowledged nor strobed.
- R7: In a write, each data byte gives exactly one single-cycle `wr_valid` pulse with `wr_data` equal to the byte (MSB received first), and the byte is acknowledged.
- R8: A STOP clears `addr_match`. Bytes clocked after it without a new START are ignored.
- R9: A START in the middle of a byte discards the partial byte, with no `wr_valid`. The strap is decoded again at that START, and the address that follows is judged afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| strap_in | input | 1 | Raw address strap pin level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_match | output | 1 | Current transfer is addressed to this target |
| rd_wr | output | 1 | Direction bit of the last matched address (1 = read) |
| wr_valid | output | 1 | One-cycle strobe: a write byte has been received |
| wr_data | output | 8 | Received write byte, valid with `wr_valid` |

## Verification
Two functions can act in the same cycle. A START that arrives in the middle of a byte has to abort the byte engine, and in that same cycle it starts a new strap decode. The bench provokes this by stopping a data byte after four bits, moving the strap from ground to supply, and issuing a repeated START. It judges the result in two ways. No strobe may appear for the partial byte. The address that follows must be acknowledged at the new supply address 0x48. The pending SCL-tie decision also resolves on the first SCL fall after START, which the byte engine must ignore, and the SCL-strap scenario checks this through the acknowledge at 0xC0.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  // Strap tie encoding: bit 1 gives address bit A7, bit 0 gives A3.
  typedef enum logic [1:0] {
    TIE_GND = 2'b00,
    TIE_VDD = 2'b01,
    TIE_SCL = 2'b10,
    TIE_SDA = 2'b11
  } strap_tie_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_AACK,
    PH_DATA,
    PH_DACK
  } phase_e;

  // Seven-bit target address: A7, fixed 100, A3, fixed 00.
  function automatic logic [6:0] own_address(input strap_tie_e tie);
    return {tie[1], 3'b100, tie[0], 2'b00};
  endfunction

endpackage

// File: rtl/tgt_sync.sv
module tgt_sync #(
  parameter int WIDTH   = 3,
  parameter int STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL}};
      else     chain <= {chain[STAGES-2:0], d_in[g]};
    end
    assign d_out[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/tgt_bus_events.sv
module tgt_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);

  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // SDA moving while SCL stays high marks START (falling) or STOP (rising).
  assign start_ev = scl_q & scl_s & sda_q & ~sda_s;
  assign stop_ev  = scl_q & scl_s & ~sda_q & sda_s;
  assign scl_rise = ~scl_q & scl_s;
  assign scl_fall = scl_q & ~scl_s;

endmodule

// File: rtl/tgt_strap_decode.sv
module tgt_strap_decode
  import i2c_tgt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_ev,
  input  logic       scl_s,
  input  logic       scl_fall,
  input  logic       strap_s,
  output strap_tie_e tie
);

  logic strap_q;
  logic pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      strap_q <= 1'b1;
      pending <= 1'b0;
      tie     <= TIE_GND;
    end else begin
      strap_q <= strap_s;
      if (start_ev) begin
        if (strap_s) begin
          pending <= 1'b1;               // supply or SCL: wait for SCL fall
          tie     <= TIE_VDD;
        end else begin
          pending <= 1'b0;
          tie     <= strap_q ? TIE_SDA : TIE_GND;  // dropped with SDA or low all along
        end
      end else if (pending && scl_fall) begin
        pending <= 1'b0;
        tie     <= strap_s ? TIE_VDD : TIE_SCL;
      end
    end
  end

  // R4: a pending SCL-tie decision only opens on a START, i.e. while SCL is high
  p_pending_scl_high_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(pending) |-> scl_s);

endmodule

// File: rtl/tgt_byte_engine.sv
module tgt_byte_engine
  import i2c_tgt_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_ev,
  input  logic            stop_ev,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            scl_s,
  input  logic            sda_s,
  input  logic [BITS-2:0] own_addr,
  output logic            sda_oe,
  output logic            addr_match,
  output logic            rd_wr,
  output logic            wr_valid,
  output logic [BITS-1:0] wr_data
);

  localparam int CW = $clog2(BITS + 1);
  localparam logic [CW-1:0] FULL = CW'(BITS);

  phase_e          phase;
  logic [BITS-1:0] shreg;
  logic [CW-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      shreg      <= '0;
      cnt        <= '0;
      sda_oe     <= 1'b0;
      addr_match <= 1'b0;
      rd_wr      <= 1'b0;
      wr_valid   <= 1'b0;
      wr_data    <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (start_ev) begin
        phase      <= PH_ADDR;
        cnt        <= '0;
        sda_oe     <= 1'b0;
        addr_match <= 1'b0;
      end else if (stop_ev) begin
        phase      <= PH_IDLE;
        cnt        <= '0;
        sda_oe     <= 1'b0;
        addr_match <= 1'b0;
      end else begin
        unique case (phase)
          PH_ADDR, PH_DATA: begin
            if (scl_rise && cnt != FULL) begin
              shreg <= {shreg[BITS-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              if (phase == PH_ADDR) begin
                if (shreg[BITS-1:1] == own_addr) begin
                  phase      <= PH_AACK;
                  sda_oe     <= 1'b1;
                  addr_match <= 1'b1;
                  rd_wr      <= shreg[0];
                end else begin
                  phase <= PH_IDLE;
                end
              end else begin
                phase    <= PH_DACK;
                sda_oe   <= 1'b1;
                wr_valid <= 1'b1;
                wr_data  <= shreg;
              end
            end
          end
          PH_AACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            phase  <= rd_wr ? PH_IDLE : PH_DATA;
          end
          PH_DACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            phase  <= PH_DATA;
          end
          default: ;
        endcase
      end
    end
  end

  // R2: the acknowledge driver only switches while SCL is low
  p_oe_moves_scl_low_r2: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  // R5: SDA is only pulled when this target was addressed
  p_oe_needs_match_r5: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> addr_match);

  // R7: the strobe is one cycle wide and only in an addressed write
  p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);
  p_valid_write_r7: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (addr_match && !rd_wr));

  // R8: STOP drops the match
  p_stop_clears_r8: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> !addr_match);

  // R9: START releases SDA and drops the match
  p_start_release_r9: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> (!sda_oe && !addr_match && !wr_valid));

endmodule

// File: rtl/i2c_strap_target.sv
module i2c_strap_target
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_BITS   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_in,
  input  logic                 sda_in,
  input  logic                 strap_in,
  output logic                 sda_oe,
  output logic                 addr_match,
  output logic                 rd_wr,
  output logic                 wr_valid,
  output logic [BYTE_BITS-1:0] wr_data
);

  localparam int LINES = 3;

  logic [LINES-1:0] raw_lines, sync_lines;
  logic scl_s, sda_s, strap_s;
  logic start_ev, stop_ev, scl_rise, scl_fall;
  strap_tie_e tie;

  assign raw_lines = {strap_in, sda_in, scl_in};
  assign {strap_s, sda_s, scl_s} = sync_lines;

  tgt_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (raw_lines),
    .d_out (sync_lines)
  );

  tgt_bus_events u_events (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall)
  );

  tgt_strap_decode u_strap (
    .clk      (clk),
    .rst      (rst),
    .start_ev (start_ev),
    .scl_s    (scl_s),
    .scl_fall (scl_fall),
    .strap_s  (strap_s),
    .tie      (tie)
  );

  tgt_byte_engine #(.BITS(BYTE_BITS)) u_engine (
    .clk        (clk),
    .rst        (rst),
    .start_ev   (start_ev),
    .stop_ev    (stop_ev),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .scl_s      (scl_s),
    .sda_s      (sda_s),
    .own_addr   (own_address(tie)),
    .sda_oe     (sda_oe),
    .addr_match (addr_match),
    .rd_wr      (rd_wr),
    .wr_valid   (wr_valid),
    .wr_data    (wr_data)
  );

endmodule

// File: tb/i2c_strap_target_tb.sv
module i2c_strap_target_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctrl_scl = 1'b1;
  logic ctrl_sda = 1'b1;
  int   strap_sel = 0;   // 0 ground, 1 supply, 2 SCL, 3 SDA

  logic sda_oe, addr_match, rd_wr, wr_valid;
  logic [7:0] wr_data;
  logic scl_line, sda_line, strap_w;

  int checks = 0;
  int errors = 0;
  int wv_cnt = 0;
  logic [7:0] wv_last = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_line = ctrl_scl;
  assign sda_line = ctrl_sda & ~sda_oe;
  assign strap_w  = (strap_sel == 0) ? 1'b0 :
                    (strap_sel == 1) ? 1'b1 :
                    (strap_sel == 2) ? scl_line : sda_line;

  i2c_strap_target dut_i (
    .clk        (clk),
    .rst        (rst),
    .scl_in     (scl_line),
    .sda_in     (sda_line),
    .strap_in   (strap_w),
    .sda_oe     (sda_oe),
    .addr_match (addr_match),
    .rd_wr      (rd_wr),
    .wr_valid   (wr_valid),
    .wr_data    (wr_data)
  );

  always @(negedge clk) begin
    if (!rst && wr_valid) begin
      wv_cnt  <= wv_cnt + 1;
      wv_last <= wr_data;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bus_start();
    ctrl_sda = 1'b1; wait_half();
    ctrl_scl = 1'b1; wait_half();
    ctrl_sda = 1'b0; wait_half();
    ctrl_scl = 1'b0; wait_half();
  endtask

  task automatic bus_stop();
    ctrl_sda = 1'b0; wait_half();
    ctrl_scl = 1'b1; wait_half();
    ctrl_sda = 1'b1; wait_half();
  endtask

  task automatic send_bit(input logic b);
    ctrl_sda = b;    wait_half();
    ctrl_scl = 1'b1; wait_half();
    ctrl_scl = 1'b0; wait_half();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    ctrl_sda = 1'b1; wait_half();
    ctrl_scl = 1'b1;
    acked = 1'b1;
    for (int k = 0; k < HALF; k++) begin
      @(negedge clk);
      if (sda_line) acked = 1'b0;
    end
    ctrl_scl = 1'b0; wait_half();
  endtask

  task automatic t_reset();
    chk("R1 sda_oe in reset", sda_oe, 0);
    chk("R1 addr_match in reset", addr_match, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 sda_oe after reset", sda_oe, 0);
    chk("R1 addr_match after reset", addr_match, 0);
    chk("R1 rd_wr after reset", rd_wr, 0);
    chk("R1 wr_valid after reset", wr_valid, 0);
  endtask

  task automatic t_ground_write();
    logic a;
    strap_sel = 0;
    bus_start();
    send_byte(8'h40, a);
    chk("R2 ground 0x40 acked", a, 1);
    chk("R2 addr_match", addr_match, 1);
    chk("R6 rd_wr write", rd_wr, 0);
    send_byte(8'hA5, a);
    chk("R7 data 0xA5 acked", a, 1);
    chk("R7 one strobe", wv_cnt, 1);
    chk("R7 data 0xA5", wv_last, 8'hA5);
    send_byte(8'h3C, a);
    chk("R7 data 0x3C acked", a, 1);
    chk("R7 second strobe", wv_cnt, 2);
    chk("R7 data 0x3C", wv_last, 8'h3C);
    bus_stop();
    chk("R8 match cleared by STOP", addr_match, 0);
    send_byte(8'h11, a);
    chk("R8 byte after STOP not acked", a, 0);
    chk("R8 no strobe after STOP", wv_cnt, 2);
  endtask

  task automatic t_supply();
    logic a;
    strap_sel = 1;
    bus_start(); send_byte(8'h48, a); bus_stop();
    chk("R2 supply 0x48 acked", a, 1);
    bus_start(); send_byte(8'h40, a); bus_stop();
    chk("R2 supply 0x40 not acked", a, 0);
  endtask

  task automatic t_sda_tie();
    logic a;
    strap_sel = 3;
    bus_start(); send_byte(8'hC8, a); bus_stop();
    chk("R3 SDA tie 0xC8 acked", a, 1);
    bus_start(); send_byte(8'hC0, a); bus_stop();
    chk("R3 SDA tie 0xC0 not acked", a, 0);
  endtask

  task automatic t_scl_tie();
    logic a;
    strap_sel = 2;
    bus_start(); send_byte(8'hC0, a); bus_stop();
    chk("R4 SCL tie 0xC0 acked", a, 1);
    bus_start(); send_byte(8'hC8, a); bus_stop();
    chk("R4 SCL tie 0xC8 not acked", a, 0);
  endtask

  task automatic t_mismatch();
    logic a;
    int base;
    strap_sel = 0;
    base = wv_cnt;
    bus_start();
    send_byte(8'hC0, a);
    chk("R5 foreign address not acked", a, 0);
    chk("R5 addr_match low", addr_match, 0);
    send_byte(8'h00, a);
    send_byte(8'h55, a);
    chk("R5 later byte not acked", a, 0);
    chk("R5 no strobe", wv_cnt, base);
    bus_stop();
  endtask

  task automatic t_read();
    logic a;
    int base;
    strap_sel = 0;
    base = wv_cnt;
    bus_start();
    send_byte(8'h41, a);
    chk("R6 read address acked", a, 1);
    chk("R6 rd_wr read", rd_wr, 1);
    send_byte(8'hFF, a);
    chk("R6 byte after read not acked", a, 0);
    chk("R6 no strobe in read", wv_cnt, base);
    bus_stop();
  endtask

  task automatic t_restart();
    logic a;
    int base;
    strap_sel = 0;
    base = wv_cnt;
    bus_start();
    send_byte(8'h40, a);
    chk("R9 first address acked", a, 1);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    strap_sel = 1;
    bus_start();
    chk("R9 match dropped at START", addr_match, 0);
    send_byte(8'h48, a);
    chk("R9 re-decoded supply 0x48 acked", a, 1);
    chk("R9 partial byte not strobed", wv_cnt, base);
    chk("R9 direction write", rd_wr, 0);
    bus_stop();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    t_ground_write();
    t_supply();
    t_sda_tie();
    t_scl_tie();
    t_mismatch();
    t_read();
    t_restart();
    repeat (10) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule